// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Controller

This block is one general-purpose I/O port of parameterised width (eight pins by default), seen by software as three register slots on a simple synchronous register bus. A direction slot and an output-data slot hold one bit per pin. A read-only sample slot returns the pad levels after a two-flop synchronizer. Every bus write carries a per-bit mask, so software can change one pin's direction or drive value without touching any other pin.

Writing ones to the sample slot flips the matching output-data bits. This gives a single-write toggle that needs no read-modify-write sequence. Each pin can be handed to a peripheral through an override input. A global input forces every pull-up off.

Each pin drives three registered outputs: output enable, output level and pull-up enable. They feed a pad ring outside this block.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the direction and output-data registers and the read data to zero. Every pin then comes up as an input, with output enable, output level and pull-up all low.
- R2: A write with `bus_addr` = 1 (direction slot) sets each direction bit whose `bus_wmask` bit is 1 to the matching `bus_wdata` bit. Masked-off bits keep their value. The change is visible from the next clock edge.
- R3: A write with `bus_addr` = 2 (output-data slot) updates the output-data bits under the same per-bit mask rule.
- R4: A write with `bus_addr` = 0 (sample slot) inverts each output-data bit where both `bus_wdata` and `bus_wmask` are 1. Zero bits have no effect, and the direction register and the sample value are never written.
- R5: A read (`bus_rd` = 1) loads `bus_rdata` on that clock edge, one cycle of latency. Without a read, `bus_rdata` holds its value.
- R6: A read of address 0 returns the `pad_in` levels as they stood two clock edges before the read edge.
- R7: With no override, `pin_oe` follows the direction bit (1 = output) and `pin_out` follows the data bit, one clock after the register changes.
- R8: With no override, `pin_pu` is 1 only when the direction bit is 0, the data bit is 1 and `pu_kill` is 0. A pin never has pull-up and output enable high together.
- R9: While `pu_kill` is high, every `pin_pu` bit is low from the next clock edge, whatever the per-pin settings.
- R10: When `alt_en[i]` is 1, `pin_oe[i]` and `pin_out[i]` take `alt_oe[i]` and `alt_val[i]` one clock later and `pin_pu[i]` is 0. Other pins keep their register-driven behaviour.
- R11: Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register slot: 0 sample, 1 direction, 2 data, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_wmask | input | W | Per-bit write enable |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | W | Registered read data |
| pu_kill | input | 1 | Global pull-up disable |
| alt_en | input | W | Per-pin peripheral override enable |
| alt_oe | input | W | Override output enable |
| alt_val | input | W | Override output level |
| pad_in | input | W | Pad levels, asynchronous |
| pin_oe | output | W | Registered output enable per pin |
| pin_out | output | W | Registered output level per pin |
| pin_pu | output | W | Registered pull-up enable per pin |

## Verification
The assertions check the pin-level rules on every cycle. A killed or overridden pin never shows a pull-up, overridden pins copy the override inputs, pull-up and output enable are never high together, and read data holds between reads.

Only the bench scenarios can show the masked write and toggle arithmetic against a reference model. They also cover the two-edge input delay, isolation of untouched pins, and the inert fourth address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int SLOT_W = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  localparam slot_t SLOT_SAMPLE = 2'd0;
  localparam slot_t SLOT_DIR    = 2'd1;
  localparam slot_t SLOT_DATA   = 2'd2;
  localparam slot_t SLOT_NONE   = 2'd3;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = gpio_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  slot_t        addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dat_q
);
  logic [W-1:0] sel_bits;
  assign sel_bits = wdata & wmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr) begin
      case (addr)
        SLOT_DIR:    dir_q <= (dir_q & ~wmask) | sel_bits;
        SLOT_DATA:   dat_q <= (dat_q & ~wmask) | sel_bits;
        SLOT_SAMPLE: dat_q <= dat_q ^ sel_bits;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic         pu_kill,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_val,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic oe_d, out_d, pu_d;
    always_comb begin
      if (alt_en[i]) begin
        oe_d  = alt_oe[i];
        out_d = alt_val[i];
        pu_d  = 1'b0;
      end else begin
        oe_d  = dir_q[i];
        out_d = dat_q[i];
        pu_d  = ~dir_q[i] & dat_q[i] & ~pu_kill;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[i]  <= 1'b0;
        pin_out[i] <= 1'b0;
        pin_pu[i]  <= 1'b0;
      end else begin
        pin_oe[i]  <= oe_d;
        pin_out[i] <= out_d;
        pin_pu[i]  <= pu_d;
      end
    end
  end
endmodule

// File: rtl/gpio_rdport.sv
module gpio_rdport
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  slot_t        addr,
  input  logic [W-1:0] sample_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  output logic [W-1:0] rdata
);
  logic [W-1:0] rsel;
  always_comb begin
    case (addr)
      SLOT_SAMPLE: rsel = sample_q;
      SLOT_DIR:    rsel = dir_q;
      SLOT_DATA:   rsel = dat_q;
      default:     rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rsel;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] bus_wmask,
  input  logic         bus_rd,
  output logic [W-1:0] bus_rdata,
  input  logic         pu_kill,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_oe,
  input  logic [W-1:0] alt_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_pu
);
  logic [W-1:0] dir_q, dat_q, sample_q;

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sample_q)
  );

  gpio_regfile #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .wmask(bus_wmask), .dir_q(dir_q), .dat_q(dat_q)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .dat_q(dat_q), .pu_kill(pu_kill),
    .alt_en(alt_en), .alt_oe(alt_oe), .alt_val(alt_val),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  gpio_rdport #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .sample_q(sample_q), .dir_q(dir_q), .dat_q(dat_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata,
  input logic         pu_kill,
  input logic [W-1:0] alt_en,
  input logic [W-1:0] alt_oe,
  input logic [W-1:0] alt_val,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_pu
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && pin_pu == '0 && bus_rdata == '0));

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r8_pu_not_with_oe: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);

  a_r9_kill_all_pu: assert property (@(posedge clk) disable iff (rst)
    pu_kill |=> pin_pu == '0);

  for (genvar i = 0; i < W; i++) begin : g_alt
    a_r10_alt_override: assert property (@(posedge clk) disable iff (rst)
      alt_en[i] |=> (pin_oe[i] == $past(alt_oe[i]) &&
                     pin_out[i] == $past(alt_val[i]) && !pin_pu[i]));
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pu_kill(pu_kill), .alt_en(alt_en), .alt_oe(alt_oe), .alt_val(alt_val),
  .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_wmask = '0;
  logic         bus_rd = 1'b0;
  logic [W-1:0] bus_rdata;
  logic         pu_kill = 1'b0;
  logic [W-1:0] alt_en = '0, alt_oe = '0, alt_val = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pin_oe, pin_out, pin_pu;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_dir = '0, m_dat = '0;
  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #4 clk = ~clk;

  gpio_port_ctrl #(.W(W)) u_gpio_port_ctrl (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d, input logic [W-1:0] m);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wmask = '0;
    case (a)
      2'd1: m_dir = (m_dir & ~m) | (d & m);
      2'd2: m_dat = (m_dat & ~m) | (d & m);
      2'd0: m_dat = m_dat ^ (d & m);
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compares read data half a cycle after the read edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && !rst) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  function automatic logic [W-1:0] exp_pu();
    return ~m_dir & m_dat & {W{~pu_kill}} & ~alt_en;
  endfunction

  task automatic check_pins(input string req);
    @(negedge clk);
    check({req, " oe"},  pin_oe,  (alt_en & alt_oe)  | (~alt_en & m_dir));
    check({req, " out"}, pin_out, (alt_en & alt_val) | (~alt_en & m_dat));
    check({req, " pu"},  pin_pu,  exp_pu());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, '0);
    check("R1 pu", pin_pu, '0);
    check("R1 rdata", bus_rdata, '0);
    rst = 1'b0;
    bus_read(2'd1, 8'h00, "R1 dir");
    bus_read(2'd2, 8'h00, "R1 data");

    // R2 masked direction write
    bus_write(2'd1, 8'hFF, 8'h0F);
    bus_read(2'd1, m_dir, "R2 dir low nibble");
    bus_write(2'd1, 8'h00, 8'h04);
    bus_read(2'd1, 8'h0B, "R2 single bit clear");

    // R3 masked data write, R7 pin outputs
    bus_write(2'd2, 8'hA5, 8'hFF);
    bus_write(2'd2, 8'h00, 8'h01);
    bus_read(2'd2, 8'hA4, "R3 single bit");
    check_pins("R7");

    // R4 toggle via sample slot
    bus_write(2'd0, 8'h3C, 8'hFF);
    bus_read(2'd2, 8'h98, "R4 toggle");
    bus_write(2'd0, 8'hFF, 8'h80);
    bus_read(2'd2, 8'h18, "R4 masked toggle");
    bus_read(2'd1, 8'h0B, "R4 dir untouched");
    bus_write(2'd0, 8'h00, 8'hFF);
    bus_read(2'd2, 8'h18, "R4 zero write");

    // R8 pull-ups
    check_pins("R8");

    // R9 global kill
    @(negedge clk); pu_kill = 1'b1;
    check_pins("R9");
    @(negedge clk); pu_kill = 1'b0;
    check_pins("R9 release");

    // R10 override on two pins
    @(negedge clk); alt_en = 8'h11; alt_oe = 8'h01; alt_val = 8'h10;
    check_pins("R10");
    @(negedge clk); alt_en = '0;
    check_pins("R10 release");

    // R6 input synchronizer delay
    @(negedge clk); pad_in = 8'h5A;
    bus_read(2'd0, 8'h00, "R6 too early");
    @(negedge clk); pad_in = 8'hC3;
    repeat (2) @(negedge clk);
    bus_read(2'd0, 8'hC3, "R6 after two edges");

    // R5 back-to-back reads and hold
    bus_read(2'd1, 8'h0B, "R5 first");
    bus_read(2'd2, 8'h18, "R5 second");
    repeat (3) @(negedge clk);
    check("R5 hold", bus_rdata, 8'h18);

    // R11 unused slot
    bus_write(2'd3, 8'hFF, 8'hFF);
    bus_read(2'd3, 8'h00, "R11 reads zero");
    bus_read(2'd1, 8'h0B, "R11 dir kept");
    bus_read(2'd2, 8'h18, "R11 data kept");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R5 queue drained", W'(exp_q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule